// File: doc/BRIEF.md
# Destination Address Match Filter

This block decides whether a frame being received is addressed to the station. It holds a small table of 48-bit station addresses. Software loads the table through a write port that takes an entry index and a value. As the receiver hands over the first six bytes of each frame, the block shifts them into an address register. One clock after the sixth byte it compares that address against every enabled entry at once. It then raises either an accept pulse or a reject pulse, and the receive path uses that pulse to keep the frame or to flush it.

The table has 21 entries, and a few of them have fixed roles. Entry 0 holds the destination and entry 1 the source of an outgoing pause control frame. Entry 18 holds that frame's length/type, opcode and operand. Entries 19 and 20 hold the fields of a user-defined control frame. A transmit path reads these entries through a combinational read port. A 21-bit enable mask selects which entries can produce a match, and by default the three entries that carry control-frame fields are left out. A promiscuous input accepts every frame. A broadcast-enable input accepts the all-ones address.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset every entry reads as zero, both decision outputs are low, hitIdx is 31, and the enable mask is 0x03FFFF (entries 0 to 17 enabled, entries 18 to 20 disabled).
- R2: When wrEn is high at a clock edge outside a compare window, entry wrIdx takes wrData. rdData then returns that value for rdIdx after the edge.
- R3: A frame starts with frameStart and byteValid high together. Each byteValid cycle after that supplies the next byte, and the first byte is compared with entry bits 47:40. In the cycle after the edge that captures the sixth byte, exactly one of matchOut or rejectOut is high, for that single cycle.
- R4: matchOut is raised when the received address equals any entry whose mask bit is 1. Otherwise rejectOut is raised, unless R6 or R7 applies.
- R5: An entry whose mask bit is 0 never causes a match. maskWe loads maskIn into the mask, with the same timing as entry writes.
- R6: The all-ones address is accepted when bcastEnIn is high in the decision cycle. When bcastEnIn is low, that address goes only through the table compare.
- R7: When promiscIn is high in the decision cycle, the result is matchOut, whatever the address.
- R8: In the decision cycle, hitIdx gives the lowest enabled entry index that matches. It is 31 when no entry matches, including accepts made through R6 or R7, and 31 outside the decision cycle.
- R9: An entry or mask write made while a compare window is open is held in a single pending slot and does not affect the frame in progress. A later write in the same window replaces it. The window runs from the cycle after the first byte through the decision cycle. The pending write takes effect at the first edge after the window closes.
- R10: byteValid cycles without a started frame, and bytes after the sixth, are ignored. A frameStart in the middle of an address restarts the count with its own byte.
- R11: A write with wrIdx of 21 or more changes nothing, and a read with rdIdx of 21 or more returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | 5 | Entry index for a write |
| wrData | input | 48 | Address value to store |
| maskWe | input | 1 | Enable-mask write strobe |
| maskIn | input | 21 | New enable mask |
| rdIdx | input | 5 | Entry index for the read port |
| rdData | output | 48 | Contents of entry rdIdx |
| frameStart | input | 1 | Marks the first destination byte of a frame |
| byteValid | input | 1 | byteIn carries a received byte |
| byteIn | input | 8 | Received byte |
| promiscIn | input | 1 | Accept every frame |
| bcastEnIn | input | 1 | Accept the all-ones address |
| matchOut | output | 1 | Single-cycle accept pulse |
| rejectOut | output | 1 | Single-cycle reject pulse |
| hitIdx | output | 5 | Lowest matching entry index, 31 if none |

## Verification
A software write to the table can land in the same cycle as an address compare that reads the table. The bench provokes this by driving wrEn together with the fourth destination byte, storing the very address being received into an entry that does not match yet. The frame must still be rejected, and the read port must still show the old value in the decision cycle. Two cycles later the new value must read back, and the next frame with that address must match at that index.

// File: rtl/cam_filter_pkg.sv
package cam_filter_pkg;

  // Strobes passed from the control FSM to the datapath
  typedef struct packed {
    logic shift;          // capture byteIn into the address register
    logic decide;         // decision cycle
    logic busy;           // compare window open
    logic capWr;          // park an entry write in the pending slot
    logic commitWr;       // write the incoming entry value now
    logic commitPend;     // drain the pending entry write
    logic capMask;        // park a mask write
    logic commitMask;     // write the incoming mask now
    logic commitPendMask; // drain the pending mask write
  } camCtrl_t;

endpackage

// File: rtl/cam_ctrl.sv
module cam_ctrl
  import cam_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int CNT_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameStart,
  input  logic     byteValid,
  input  logic     wrEn,
  input  logic     maskWe,
  output camCtrl_t ctrl
);

  logic [CNT_W-1:0] byteCnt, nextCnt;
  logic             inAddr, shiftNow, decideQ, busyNow;
  logic             pendWr, pendMask;

  assign inAddr   = (byteCnt != '0) && (byteCnt < CNT_W'(ADDR_BYTES));
  assign shiftNow = byteValid && (frameStart || inAddr);
  assign busyNow  = inAddr || decideQ;

  always_comb begin
    if (frameStart)    nextCnt = byteValid ? CNT_W'(1) : '0;
    else if (shiftNow) nextCnt = byteCnt + CNT_W'(1);
    else               nextCnt = byteCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt  <= '0;
      decideQ  <= 1'b0;
      pendWr   <= 1'b0;
      pendMask <= 1'b0;
    end else begin
      byteCnt  <= nextCnt;
      decideQ  <= shiftNow && (nextCnt == CNT_W'(ADDR_BYTES));
      pendWr   <= busyNow ? (pendWr | wrEn) : 1'b0;
      pendMask <= busyNow ? (pendMask | maskWe) : 1'b0;
    end
  end

  always_comb begin
    ctrl.shift          = shiftNow;
    ctrl.decide         = decideQ;
    ctrl.busy           = busyNow;
    ctrl.capWr          = busyNow && wrEn;
    ctrl.commitWr       = !busyNow && wrEn;
    ctrl.commitPend     = !busyNow && pendWr;
    ctrl.capMask        = busyNow && maskWe;
    ctrl.commitMask     = !busyNow && maskWe;
    ctrl.commitPendMask = !busyNow && pendMask;
  end

  // R3
  decide_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    decideQ |=> !decideQ);

  // R9
  pend_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyNow && !wrEn && !maskWe) |=> (!pendWr && !pendMask));

endmodule

// File: rtl/cam_datapath.sv
module cam_datapath
  import cam_filter_pkg::*;
#(
  parameter int                   NUM_ENTRIES = 21,
  parameter int                   ADDR_W      = 48,
  parameter int                   BYTE_W      = 8,
  parameter int                   IDX_W       = 5,
  parameter logic [NUM_ENTRIES-1:0] MASK_RESET = 21'h03FFFF,
  localparam logic [IDX_W-1:0]    NONE_IDX    = '1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  camCtrl_t               ctrl,
  input  logic [BYTE_W-1:0]      byteIn,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [ADDR_W-1:0]      wrData,
  input  logic [NUM_ENTRIES-1:0] maskIn,
  input  logic [IDX_W-1:0]       rdIdx,
  input  logic                   promiscIn,
  input  logic                   bcastEnIn,
  output logic [ADDR_W-1:0]      rdData,
  output logic                   matchOut,
  output logic                   rejectOut,
  output logic [IDX_W-1:0]       hitIdx
);

  logic [ADDR_W-1:0]      entryMem [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] maskReg, pendMaskVal, hitVec;
  logic [ADDR_W-1:0]      addrReg, pendData;
  logic [IDX_W-1:0]       pendIdx, firstIdx;
  logic                   anyHit, isBcast, accept;

  // Pending slot for writes that arrive inside a compare window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendIdx     <= '0;
      pendData    <= '0;
      pendMaskVal <= '0;
    end else begin
      if (ctrl.capWr) begin
        pendIdx  <= wrIdx;
        pendData <= wrData;
      end
      if (ctrl.capMask) pendMaskVal <= maskIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    maskReg <= MASK_RESET;
    else if (ctrl.commitMask)     maskReg <= maskIn;
    else if (ctrl.commitPendMask) maskReg <= pendMaskVal;
  end

  // Received address, first byte ends up in the top bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           addrReg <= '0;
    else if (ctrl.shift) addrReg <= {addrReg[ADDR_W-BYTE_W-1:0], byteIn};
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        entryMem[i] <= '0;
      else if (ctrl.commitWr && wrIdx == IDX_W'(i))
        entryMem[i] <= wrData;
      else if (ctrl.commitPend && pendIdx == IDX_W'(i))
        entryMem[i] <= pendData;
    end

    assign hitVec[i] = maskReg[i] && (entryMem[i] == addrReg);

    // R9
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.busy |=> $stable(entryMem[i]));
  end

  always_comb begin
    firstIdx = NONE_IDX;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (hitVec[i]) firstIdx = IDX_W'(i);
  end

  assign anyHit  = |hitVec;
  assign isBcast = &addrReg;
  assign accept  = promiscIn || (bcastEnIn && isBcast) || anyHit;

  assign matchOut  = ctrl.decide && accept;
  assign rejectOut = ctrl.decide && !accept;
  assign hitIdx    = (ctrl.decide && anyHit) ? firstIdx : NONE_IDX;

  assign rdData = (rdIdx < IDX_W'(NUM_ENTRIES)) ? entryMem[rdIdx] : '0;

  // R8
  hit_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchOut && hitIdx != NONE_IDX) |-> maskReg[hitIdx]);

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.busy |=> $stable(maskReg));

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import cam_filter_pkg::*;
#(
  parameter int                   NUM_ENTRIES = 21,
  parameter int                   ADDR_W      = 48,
  parameter int                   BYTE_W      = 8,
  parameter int                   IDX_W       = $clog2(NUM_ENTRIES),
  parameter logic [NUM_ENTRIES-1:0] MASK_RESET = 21'h03FFFF,
  localparam int                  ADDR_BYTES  = ADDR_W / BYTE_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [ADDR_W-1:0]      wrData,
  input  logic                   maskWe,
  input  logic [NUM_ENTRIES-1:0] maskIn,
  input  logic [IDX_W-1:0]       rdIdx,
  output logic [ADDR_W-1:0]      rdData,
  input  logic                   frameStart,
  input  logic                   byteValid,
  input  logic [BYTE_W-1:0]      byteIn,
  input  logic                   promiscIn,
  input  logic                   bcastEnIn,
  output logic                   matchOut,
  output logic                   rejectOut,
  output logic [IDX_W-1:0]       hitIdx
);

  camCtrl_t ctrl;

  cam_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .byteValid (byteValid),
    .wrEn      (wrEn),
    .maskWe    (maskWe),
    .ctrl      (ctrl)
  );

  cam_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ADDR_W     (ADDR_W),
    .BYTE_W     (BYTE_W),
    .IDX_W      (IDX_W),
    .MASK_RESET (MASK_RESET)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .byteIn   (byteIn),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .maskIn   (maskIn),
    .rdIdx    (rdIdx),
    .promiscIn(promiscIn),
    .bcastEnIn(bcastEnIn),
    .rdData   (rdData),
    .matchOut (matchOut),
    .rejectOut(rejectOut),
    .hitIdx   (hitIdx)
  );

  // R3
  one_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({matchOut, rejectOut}));

  // R3
  result_after_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchOut || rejectOut) |-> $past(byteValid));

  // R7
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    promiscIn |-> !rejectOut);

endmodule

// File: tb/dest_addr_filter_test.sv
module dest_addr_filter_test;

  localparam int N = 21;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, maskWe = 1'b0;
  logic [4:0]  wrIdx = '0, rdIdx = '0;
  logic [47:0] wrData = '0;
  logic [20:0] maskIn = '0;
  logic        frameStart = 1'b0, byteValid = 1'b0;
  logic [7:0]  byteIn = '0;
  logic        promiscIn = 1'b0, bcastEnIn = 1'b0;
  logic [47:0] rdData;
  logic        matchOut, rejectOut;
  logic [4:0]  hitIdx;

  int total = 0;
  int bad = 0;

  logic [47:0] refE [N];
  logic [20:0] refM;
  logic [47:0] pool [8];

  dest_addr_filter uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .maskWe(maskWe), .maskIn(maskIn), .rdIdx(rdIdx), .rdData(rdData),
    .frameStart(frameStart), .byteValid(byteValid), .byteIn(byteIn),
    .promiscIn(promiscIn), .bcastEnIn(bcastEnIn),
    .matchOut(matchOut), .rejectOut(rejectOut), .hitIdx(hitIdx)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit expAcc(input logic [47:0] a, input bit pr, input bit bc);
    if (pr) return 1'b1;
    if (bc && a == '1) return 1'b1;
    for (int i = 0; i < N; i++) if (refM[i] && refE[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [4:0] expIdx(input logic [47:0] a);
    for (int i = 0; i < N; i++) if (refM[i] && refE[i] == a) return 5'(i);
    return 5'd31;
  endfunction

  task automatic wrEntry(input logic [4:0] idx, input logic [47:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (idx < 5'(N)) refE[idx] = d;
  endtask

  task automatic wrMask(input logic [20:0] m);
    @(negedge clk);
    maskWe = 1'b1; maskIn = m;
    @(negedge clk);
    maskWe = 1'b0;
    refM = m;
  endtask

  task automatic readChk(input string req, input logic [4:0] idx, input logic [47:0] exp);
    rdIdx = idx;
    #1;
    check(req, rdData, exp);
  endtask

  // Sends six bytes (optional idle gaps), then checks the decision cycle
  // and that the pulse is gone one cycle later.
  task automatic sendFrame(input string req, input logic [47:0] a,
                           input bit pr, input bit bc, input int gap);
    bit acc;
    logic [4:0] ix;
    acc = expAcc(a, pr, bc);
    ix  = expIdx(a);
    for (int b = 0; b < 6; b++) begin
      @(negedge clk);
      frameStart = (b == 0);
      byteValid  = 1'b1;
      byteIn     = a[47-8*b -: 8];
      promiscIn  = pr;
      bcastEnIn  = bc;
      if (gap > 0 && b < 5) begin
        @(negedge clk);
        frameStart = 1'b0;
        byteValid  = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    frameStart = 1'b0;
    byteValid  = 1'b0;
    #1;
    check({req, " match"}, 64'(matchOut), 64'(acc));
    check({req, " reject"}, 64'(rejectOut), 64'(!acc));
    check({req, " hitIdx"}, 64'(hitIdx), 64'(ix));
    @(negedge clk);
    check("R3 pulse single cycle", 64'({matchOut, rejectOut}), 64'd0);
    promiscIn = 1'b0;
    bcastEnIn = 1'b0;
  endtask

  // Bytes without frameStart: no decision may appear
  task automatic sendLoose(input int cnt);
    for (int b = 0; b < cnt; b++) begin
      @(negedge clk);
      frameStart = 1'b0; byteValid = 1'b1; byteIn = 8'hA5;
    end
    @(negedge clk);
    byteValid = 1'b0;
    repeat (2) begin
      check("R10 ignored bytes give no decision", 64'({matchOut, rejectOut}), 64'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    #1_900_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] aA, aB, aC, aD;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) refE[i] = '0;
    refM = 21'h03FFFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 matchOut", 64'(matchOut), 64'd0);
    check("R1 rejectOut", 64'(rejectOut), 64'd0);
    check("R1 hitIdx", 64'(hitIdx), 64'd31);
    readChk("R1 entry0", 5'd0, '0);
    readChk("R1 entry20", 5'd20, '0);
    // zero address hits entry 0 through default mask
    sendFrame("R1 default mask zero addr", 48'h0, 1'b0, 1'b0, 0);

    aA = 48'h0011_2233_4455;
    aB = 48'h0180_C200_0001;
    aC = 48'h7766_5544_3322;
    aD = 48'h00AA_BBCC_DDEE;

    // R2 write / read back
    wrEntry(5'd3, aA);
    readChk("R2 readback entry3", 5'd3, aA);
    for (int i = 0; i < N; i++) if (i != 3) wrEntry(5'(i), 48'h0F0F_0000_0000 + 48'(i));
    refE[3] = aA;
    sendFrame("R4 match entry3", aA, 1'b0, 1'b0, 0);
    sendFrame("R4 unknown reject", aC, 1'b0, 1'b0, 1);

    // R5 mask
    wrEntry(5'd19, aB);
    sendFrame("R5 masked entry19 reject", aB, 1'b0, 1'b0, 0);
    wrMask(21'h0FFFFF);
    sendFrame("R5 enabled entry19 match", aB, 1'b0, 1'b0, 2);
    wrMask(21'h0FFFF7);
    sendFrame("R5 disabled entry3 reject", aA, 1'b0, 1'b0, 0);
    wrMask(21'h03FFFF);

    // R8 priority
    wrEntry(5'd7, aA);
    sendFrame("R8 lowest of 3 and 7", aA, 1'b0, 1'b0, 0);
    wrEntry(5'd3, aC);
    sendFrame("R8 entry7 after overwrite", aA, 1'b0, 1'b0, 0);

    // R6 broadcast
    sendFrame("R6 bcast disabled", '1, 1'b0, 1'b0, 0);
    sendFrame("R6 bcast enabled", '1, 1'b0, 1'b1, 0);

    // R7 promiscuous
    sendFrame("R7 promisc unknown", aD, 1'b1, 1'b0, 0);

    // R11 out of range
    wrEntry(5'd25, aD);
    readChk("R11 read idx25", 5'd25, '0);
    sendFrame("R11 oor write no match", aD, 1'b0, 1'b0, 0);

    // R10 loose and trailing bytes, restart
    sendLoose(7);
    sendLoose(3);
    @(negedge clk);
    frameStart = 1'b1; byteValid = 1'b1; byteIn = 8'hEE;
    @(negedge clk);
    frameStart = 1'b0; byteIn = 8'hDD;
    @(negedge clk);
    byteValid = 1'b0;
    sendFrame("R10 restart mid address", aA, 1'b0, 1'b0, 0);

    // R9 write during compare window collides with the compare
    wrEntry(5'd10, aC);
    for (int b = 0; b < 6; b++) begin
      @(negedge clk);
      frameStart = (b == 0); byteValid = 1'b1; byteIn = aD[47-8*b -: 8];
      wrEn = (b == 3); wrIdx = 5'd10; wrData = aD;
    end
    @(negedge clk);
    wrEn = 1'b0; byteValid = 1'b0;
    rdIdx = 5'd10;
    #1;
    check("R9 busy write not used match", 64'(matchOut), 64'd0);
    check("R9 busy write not used reject", 64'(rejectOut), 64'd1);
    check("R9 old value in decision cycle", rdData, aC);
    @(negedge clk);
    @(negedge clk);
    readChk("R9 pending write landed", 5'd10, aD);
    refE[10] = aD;
    sendFrame("R9 next frame sees write", aD, 1'b0, 1'b0, 0);

    // R9 mask write during the window
    for (int b = 0; b < 6; b++) begin
      @(negedge clk);
      frameStart = (b == 0); byteValid = 1'b1; byteIn = aD[47-8*b -: 8];
      maskWe = (b == 2); maskIn = 21'h0;
    end
    @(negedge clk);
    maskWe = 1'b0; byteValid = 1'b0;
    #1;
    check("R9 busy mask write deferred", 64'(matchOut), 64'd1);
    @(negedge clk);
    refM = 21'h0;
    sendFrame("R9 mask applied next frame", aD, 1'b0, 1'b0, 0);
    wrMask(21'h03FFFF);

    // Random mix
    for (int i = 0; i < 8; i++) pool[i] = {$urandom, $urandom} >> 16;
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [47:0] a;
      op = $urandom_range(0, 9);
      if (op < 3) begin
        wrEntry(5'($urandom_range(0, N - 1)), pool[$urandom_range(0, 7)]);
      end else if (op == 3) begin
        wrMask(21'($urandom) | 21'h1);
      end else begin
        case ($urandom_range(0, 5))
          0:       a = '1;
          1:       a = {$urandom, $urandom} >> 16;
          default: a = pool[$urandom_range(0, 7)];
        endcase
        sendFrame("R4 random frame", a, ($urandom_range(0, 7) == 0),
                  1'($urandom), $urandom_range(0, 2));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule